// File: doc/BRIEF.md
# Scanline DMA Event Timing Generator

This block watches a horizontal and a vertical raster position that are produced elsewhere. From them it derives the points in each scanline and each frame at which a DMA controller must start work, and when the memory must pause for a refresh. It keeps a 3-bit DMA phase that builds up from line to line. The event positions shift with that phase, and the way they shift depends on a chip revision select. Every event comes out as a registered single-clock strobe. The refresh event also raises a stall request that stays high for a fixed number of clocks.

A second accumulator counts elapsed clocks, taken from a per-cycle advance input. It pulses a poll strobe each time the total crosses a fixed period, and it keeps the remainder for the next period. Making the raster counters, running the transfers and performing the memory accesses are the surrounding logic's job.

Top module: `scan_evt_gen`

## Requirements
- R1: `dma_phase` always equals the stored line phase plus `hpos`, modulo 8.
- R2: A new line starts in a cycle where `hpos` is 0 and either the previous `hpos` was non-zero or no line has started since reset. At a new line the stored phase advances by the clock count latched for the previous line, modulo 8, and `line_clocks` is then latched for the new line. The latched count is 0 after reset.
- R3: At the start of a line with `vpos` = 0, the frame-init position is set from the new phase p. It is 20 − p when `chip_rev` = 1 and 12 + p for any other revision. `hinit_stb` then fires once in that frame.
- R4: When `chip_rev` = 2, the refresh position is reloaded at every line start as 538 − p. For other revisions it keeps its reset value of 538.
- R5: `refresh_stb` fires once in every line. `refresh_stall` goes high together with it and stays high for exactly 40 clocks.
- R6: On lines with `vpos` < `vis_lines`, `hrun_stb` fires once, at position 1104. On other lines it does not fire.
- R7: Each event strobe is high for one clock, in the cycle after the first sampled cycle of its period in which `hpos` is at or past the event position. No event fires in a line-start cycle.
- R8: `adv` is added to an accumulator on every clock. When the sum reaches 256, `poll_stb` pulses in the next cycle and the accumulator keeps the sum minus 256.
- R9: During reset all strobes and the stall are low. No frame-init, refresh or line-run event fires before the first line start that sets it up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | input | HW | Horizontal raster position |
| vpos | input | VW | Vertical line number |
| line_clocks | input | HW | Clock count of the current line |
| chip_rev | input | 2 | Revision select (1 and 2 have special placement) |
| vis_lines | input | VW | Number of visible lines |
| adv | input | AW | Clocks elapsed this cycle, for the poll accumulator |
| dma_phase | output | 3 | Current DMA phase |
| hinit_stb | output | 1 | Once-per-frame init event |
| hrun_stb | output | 1 | Per-visible-line run event |
| refresh_stb | output | 1 | Per-line refresh event |
| refresh_stall | output | 1 | Refresh stall request, 40 clocks |
| poll_stb | output | 1 | Poll period reached |

## Verification
Line lengths in the stimulus rotate over seven values, so the accumulated phase takes every residue modulo 8 and the init and refresh positions move from line to line. The same frames are played under revision 1, revision 2 and a third revision. This separates the subtractive init placement, the additive placement, the per-line refresh reload and the fixed refresh position. Frames hold more lines than `vis_lines`, which shows that the run event is held back on the lines past the visible count. The advance input follows an irregular pattern so that the remainder carried after each poll strobe matters.

// File: rtl/scan_evt_gen.sv
module scan_evt_gen #(
  parameter int HW          = 11,
  parameter int VW          = 9,
  parameter int AW          = 6,
  parameter int HINIT_BASE  = 12,
  parameter int REF_BASE    = 530,
  parameter int HRUN_POS    = 1104,
  parameter int STALL_CYC   = 40,
  parameter int POLL_PERIOD = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic [HW-1:0] line_clocks,
  input  logic [1:0]    chip_rev,
  input  logic [VW-1:0] vis_lines,
  input  logic [AW-1:0] adv,
  output logic [2:0]    dma_phase,
  output logic          hinit_stb,
  output logic          hrun_stb,
  output logic          refresh_stb,
  output logic          refresh_stall,
  output logic          poll_stb
);
  localparam int PH      = 3;
  localparam int PH_MOD  = 1 << PH;
  localparam int REF_DEF = REF_BASE + PH_MOD;
  localparam int SW      = $clog2(STALL_CYC + 1);
  localparam int ACW     = $clog2(POLL_PERIOD + (1 << AW));

  logic [HW-1:0]  prev_h, cur_len, init_pos, ref_pos;
  logic [PH-1:0]  lphase;
  logic           started, init_done, ref_done, run_done;
  logic [SW-1:0]  stall_cnt;
  logic [ACW-1:0] acc;

  wire            line_start = (hpos == '0) && (!started || prev_h != '0);
  wire [PH-1:0]   nphase     = lphase + cur_len[PH-1:0];
  wire [HW-1:0]   init_next  = (chip_rev == 2'd1)
                             ? HW'(HINIT_BASE + PH_MOD) - HW'(nphase)
                             : HW'(HINIT_BASE) + HW'(nphase);
  wire            fire_init  = !line_start && !init_done && hpos >= init_pos;
  wire            fire_ref   = !line_start && !ref_done && hpos >= ref_pos;
  wire            fire_run   = !line_start && !run_done && hpos >= HW'(HRUN_POS);
  wire [ACW-1:0]  acc_sum    = acc + ACW'(adv);
  wire            poll_hit   = acc_sum >= ACW'(POLL_PERIOD);

  assign dma_phase     = lphase + hpos[PH-1:0];
  assign refresh_stall = stall_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_h    <= '0;
      started   <= 1'b0;
      cur_len   <= '0;
      lphase    <= '0;
      init_pos  <= HW'(HINIT_BASE);
      ref_pos   <= HW'(REF_DEF);
      init_done <= 1'b1;
      ref_done  <= 1'b1;
      run_done  <= 1'b1;
    end else begin
      prev_h  <= hpos;
      started <= 1'b1;
      if (line_start) begin
        lphase   <= nphase;
        cur_len  <= line_clocks;
        ref_done <= 1'b0;
        if (vpos == '0) begin
          init_pos  <= init_next;
          init_done <= 1'b0;
        end
        if (chip_rev == 2'd2) ref_pos <= HW'(REF_DEF) - HW'(nphase);
        if (vpos < vis_lines) run_done <= 1'b0;
      end else begin
        if (fire_init) init_done <= 1'b1;
        if (fire_ref)  ref_done  <= 1'b1;
        if (fire_run)  run_done  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hinit_stb   <= 1'b0;
      hrun_stb    <= 1'b0;
      refresh_stb <= 1'b0;
      poll_stb    <= 1'b0;
      stall_cnt   <= '0;
      acc         <= '0;
    end else begin
      hinit_stb   <= fire_init;
      hrun_stb    <= fire_run;
      refresh_stb <= fire_ref;
      poll_stb    <= poll_hit;
      acc         <= poll_hit ? acc_sum - ACW'(POLL_PERIOD) : acc_sum;
      if (fire_ref)               stall_cnt <= SW'(STALL_CYC);
      else if (stall_cnt != '0)   stall_cnt <= stall_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/scan_evt_chk.sv
module scan_evt_chk #(
  parameter int HW          = 11,
  parameter int ACW         = 9,
  parameter int HINIT_BASE  = 12,
  parameter int REF_BASE    = 530,
  parameter int POLL_PERIOD = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hinit_stb,
  input logic           hrun_stb,
  input logic           refresh_stb,
  input logic           refresh_stall,
  input logic           line_start,
  input logic [1:0]     chip_rev,
  input logic [2:0]     lphase,
  input logic [HW-1:0]  init_pos,
  input logic [HW-1:0]  ref_pos,
  input logic [ACW-1:0] acc
);
  a_r7_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hinit_stb |=> !hinit_stb);
  a_r7_run_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hrun_stb |=> !hrun_stb);
  a_r5_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_stb |=> !refresh_stb);
  a_r5_stall_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_stall) |-> refresh_stb);
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(lphase));
  a_r3_init_range: assert property (@(posedge clk) disable iff (!rst_n)
    init_pos >= HW'(HINIT_BASE) && init_pos <= HW'(HINIT_BASE + 8));
  a_r4_ref_range: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && chip_rev == 2'd2) |=> (ref_pos > HW'(REF_BASE) && ref_pos <= HW'(REF_BASE + 8)));
  a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACW'(POLL_PERIOD));
endmodule

bind scan_evt_gen scan_evt_chk #(
  .HW(HW), .ACW(ACW), .HINIT_BASE(HINIT_BASE), .REF_BASE(REF_BASE), .POLL_PERIOD(POLL_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hinit_stb(hinit_stb), .hrun_stb(hrun_stb),
  .refresh_stb(refresh_stb), .refresh_stall(refresh_stall), .line_start(line_start),
  .chip_rev(chip_rev), .lphase(lphase), .init_pos(init_pos), .ref_pos(ref_pos), .acc(acc)
);

// File: tb/scan_evt_gen_tb.sv
module scan_evt_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] hpos = '0, line_clocks = '0;
  logic [8:0]  vpos = '0, vis_lines = 9'd5;
  logic [1:0]  chip_rev = 2'd1;
  logic [5:0]  adv = '0;
  logic [2:0]  dma_phase;
  logic        hinit_stb, hrun_stb, refresh_stb, refresh_stall, poll_stb;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cnt_init = 0, cnt_run = 0, cnt_ref = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scan_evt_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .line_clocks(line_clocks),
    .chip_rev(chip_rev), .vis_lines(vis_lines), .adv(adv), .dma_phase(dma_phase),
    .hinit_stb(hinit_stb), .hrun_stb(hrun_stb), .refresh_stb(refresh_stb),
    .refresh_stall(refresh_stall), .poll_stb(poll_stb)
  );

  // behavioural reference
  int  m_lp = 0, m_len = 0, m_prev = 0, m_ip = 12, m_rp = 538, m_st = 0, m_acc = 0;
  bit  m_started = 0, m_idone = 1, m_rdone = 1, m_udone = 1;
  bit  e_init = 0, e_run = 0, e_ref = 0, e_poll = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lp = 0; m_len = 0; m_prev = 0; m_ip = 12; m_rp = 538; m_st = 0; m_acc = 0;
      m_started = 0; m_idone = 1; m_rdone = 1; m_udone = 1;
      e_init = 0; e_run = 0; e_ref = 0; e_poll = 0;
    end else begin
      bit ls;
      int h;
      h = int'(hpos);
      ls = (h == 0) && (!m_started || m_prev != 0);
      m_started = 1; m_prev = h;
      e_init = 0; e_run = 0; e_ref = 0;
      if (ls) begin
        m_lp = (m_lp + m_len) % 8;
        m_len = int'(line_clocks);
        m_rdone = 0;
        if (vpos == 0) begin
          m_ip = (chip_rev == 1) ? 20 - m_lp : 12 + m_lp;
          m_idone = 0;
        end
        if (chip_rev == 2) m_rp = 538 - m_lp;
        if (vpos < vis_lines) m_udone = 0;
      end else begin
        if (!m_idone && h >= m_ip)  begin e_init = 1; m_idone = 1; end
        if (!m_rdone && h >= m_rp)  begin e_ref  = 1; m_rdone = 1; end
        if (!m_udone && h >= 1104)  begin e_run  = 1; m_udone = 1; end
      end
      if (e_ref) m_st = 40; else if (m_st > 0) m_st--;
      m_acc += int'(adv);
      e_poll = (m_acc >= 256);
      if (e_poll) m_acc -= 256;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 dma_phase", int'(dma_phase), (m_lp + int'(hpos)) % 8);
    chk("R3 hinit_stb", int'(hinit_stb), int'(e_init));
    chk("R6 hrun_stb", int'(hrun_stb), int'(e_run));
    chk("R5 refresh_stb", int'(refresh_stb), int'(e_ref));
    chk("R5 refresh_stall", int'(refresh_stall), int'(m_st > 0));
    chk("R8 poll_stb", int'(poll_stb), int'(e_poll));
    if (hinit_stb) cnt_init++;
    if (hrun_stb) cnt_run++;
    if (refresh_stb) cnt_ref++;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 reset hinit", int'(hinit_stb), 0);
    chk("R9 reset hrun", int'(hrun_stb), 0);
    chk("R9 reset refresh", int'(refresh_stb | refresh_stall), 0);
    chk("R9 reset poll", int'(poll_stb), 0);
    rst_n = 1'b1;
    foreach (chip_rev_list[r]) begin
      chip_rev = chip_rev_list[r];
      for (int f = 0; f < 2; f++) begin
        for (int ln = 0; ln < 8; ln++) begin
          int len;
          len = 1361 + ((ln * 5 + f * 3 + r) % 7);   // R2: varying line lengths
          vpos = 9'(ln);
          line_clocks = 11'(len);
          for (int h = 0; h < len; h++) begin
            hpos = 11'(h);
            adv = 6'((cyc * 13 + 5) % 64);
            @(negedge clk);
            cyc++;
            compare();
          end
        end
      end
    end
    repeat (2) @(negedge clk) compare();
    // R3, R6, R5: event totals per frame and line
    chk("R3 init count", cnt_init, 6);
    chk("R6 run count", cnt_run, 30);
    chk("R5 refresh count", cnt_ref, 48);
    summary();
  end

  logic [1:0] chip_rev_list [3] = '{2'd1, 2'd2, 2'd0};
endmodule